// File: doc/BRIEF.md
# Supply-Fail Reset Stretcher

The block turns a digital undervoltage indication, produced by an external comparator and asynchronous to the local clock, into a clean system reset. The flag first passes through a two-stage synchronizer. A qualification counter then measures how long the synchronized flag stays high without a break. Only a dip that outlasts the qualification window asserts reset. Once reset is asserted, a second counter measures how long the supply has been good without a break. Reset is released only after that count spans the full hold interval. Any renewed dip during the hold restarts the interval from zero.

Both intervals are given in physical units, as a clock rate in kHz, a filter time in ns and a hold time in µs. The block converts them to cycle counts at elaboration. With the default values the filter is 4 µs and the hold is 140 ms at 100 MHz. The block powers up with reset asserted and treats the supply as failed until a full hold has elapsed. A parameter selects active-high or active-low output. The output is a register driven at all times.

Top module: `por_stretch`

## Requirements
- R1: While the synchronized flag stays high beyond the qualification window, reset remains asserted.
- R2: Reset deasserts on the (HOLD_CYC+2)-th rising edge, counting from and including the first edge that samples the flag low. HOLD_CYC is CLK_KHZ*HOLD_US/1000.
- R3: A flag pulse that lasts FILT_CYC clock cycles or fewer leaves reset deasserted. FILT_CYC is CLK_KHZ*FILT_NS/1000000.
- R4: A flag pulse of FILT_CYC+1 cycles asserts reset. The assertion appears on the (FILT_CYC+3)-th rising edge, counting from and including the first edge that samples the flag high.
- R5: If the flag goes high again for even one cycle while reset is held, the hold count restarts. Release then follows R2, measured from the last fall of the flag.
- R6: From power-up, reset is asserted before the first clock edge. With the flag low from the start, reset is released only on edge HOLD_CYC+2.
- R7: With ACTIVE_HIGH=1 the output is 1 when reset is asserted and 0 otherwise. With ACTIVE_HIGH=0 the levels are inverted. The output is always a defined 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| uv_async_i | input | 1 | Undervoltage flag from the comparator, asynchronous, 1 = supply below threshold |
| rst_o | output | 1 | System reset, polarity set by ACTIVE_HIGH |

## Verification
The hardest case to reach is a new dip that arrives in the middle of a hold. The hold must be restarted rather than finished or ignored. The stimulus qualifies a dip and lets the flag fall. It then raises the flag for a single cycle about halfway through the hold. The checks require reset to still be asserted past the point where the first hold would have ended, and to fall exactly one hold after the single-cycle pulse. The filter boundary is approached from both sides: one pulse lasts exactly the filter length and one lasts a single cycle longer.

// File: rtl/por_stretch.sv
module por_stretch #(
  parameter int unsigned CLK_KHZ     = 100_000,
  parameter int unsigned FILT_NS     = 4_000,
  parameter int unsigned HOLD_US     = 140_000,
  parameter bit          ACTIVE_HIGH = 1'b0
) (
  input  logic clk_i,
  input  logic uv_async_i,
  output logic rst_o
);
  localparam int unsigned FILT_CYC = int'((64'(CLK_KHZ) * 64'(FILT_NS)) / 64'd1_000_000);
  localparam int unsigned HOLD_CYC = int'((64'(CLK_KHZ) * 64'(HOLD_US)) / 64'd1_000);
  localparam int unsigned FW = $clog2(FILT_CYC + 1);
  localparam int unsigned HW = $clog2(HOLD_CYC + 1);
  localparam logic [FW-1:0] FILT_TOP = FW'(FILT_CYC);
  localparam logic [HW-1:0] HOLD_TOP = HW'(HOLD_CYC - 1);

  logic uv_s1 = 1'b1;
  logic uv_s2 = 1'b1;
  logic asrt_q = 1'b1;
  logic [FW-1:0] filt_q = '0;
  logic [HW-1:0] hold_q = '0;

  always_ff @(posedge clk_i) begin
    uv_s1 <= uv_async_i;
    uv_s2 <= uv_s1;
  end

  always_ff @(posedge clk_i) begin
    if (!asrt_q) begin
      hold_q <= '0;
      if (!uv_s2) begin
        filt_q <= '0;
      end else if (filt_q == FILT_TOP) begin
        filt_q <= '0;
        asrt_q <= 1'b1;
      end else begin
        filt_q <= filt_q + 1'b1;
      end
    end else begin
      filt_q <= '0;
      if (uv_s2) begin
        hold_q <= '0;
      end else if (hold_q == HOLD_TOP) begin
        hold_q <= '0;
        asrt_q <= 1'b0;
      end else begin
        hold_q <= hold_q + 1'b1;
      end
    end
  end

  assign rst_o = ACTIVE_HIGH ? asrt_q : ~asrt_q;
endmodule

module por_stretch_chk #(
  parameter int unsigned FILT_CYC = 4,
  parameter int unsigned HOLD_CYC = 40
) (
  input logic clk,
  input logic uv_s,
  input logic asrt,
  input logic rst_o
);
  logic [1:0]  age   = '0;
  logic [31:0] bad_n = '0;
  logic [31:0] ok_n  = '0;
  logic [31:0] since = '0;
  logic armed;

  assign armed = (age == 2'd3);

  always_ff @(posedge clk) begin
    if (!armed) age <= age + 2'd1;
    bad_n <= uv_s ? ((bad_n > FILT_CYC + 1) ? bad_n : bad_n + 1) : '0;
    ok_n  <= uv_s ? '0 : ((ok_n > HOLD_CYC) ? ok_n : ok_n + 1);
    since <= (since > HOLD_CYC + 2) ? since : since + 1;
  end

  // R1
  p_stays_low_r1: assert property (@(posedge clk) disable iff (!armed)
    (bad_n >= FILT_CYC + 1) |-> asrt);
  // R2 and R5: release only after an unbroken good run of a full hold
  p_full_hold_r2: assert property (@(posedge clk) disable iff (!armed)
    $fell(asrt) |-> (ok_n >= HOLD_CYC));
  p_restart_r5: assert property (@(posedge clk) disable iff (!armed)
    (asrt && uv_s) |=> asrt);
  // R3 and R4
  p_glitch_r3: assert property (@(posedge clk) disable iff (!armed)
    $rose(asrt) |-> (bad_n >= FILT_CYC + 1));
  // R6
  p_boot_hold_r6: assert property (@(posedge clk) disable iff (!armed)
    !asrt |-> (since > HOLD_CYC));
  // R7
  p_driven_r7: assert property (@(posedge clk) disable iff (!armed)
    !$isunknown(rst_o));
endmodule

bind por_stretch por_stretch_chk #(.FILT_CYC(FILT_CYC), .HOLD_CYC(HOLD_CYC)) chk_i (
  .clk(clk_i), .uv_s(uv_s2), .asrt(asrt_q), .rst_o(rst_o));

// File: tb/por_stretch_tb.sv
module por_stretch_tb_top;
  localparam int unsigned FILT = 4;
  localparam int unsigned HOLD = 40;

  typedef struct {
    int unsigned cyc;
    bit          asrt;
    string       tag;
  } exp_t;

  logic clk = 1'b1;
  logic uv  = 1'b0;
  logic rst_lo, rst_hi;
  int unsigned cyc = 0;
  int total = 0;
  int bad = 0;
  exp_t sbq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  por_stretch #(.CLK_KHZ(1000), .FILT_NS(4000), .HOLD_US(40), .ACTIVE_HIGH(1'b0)) dut_i (
    .clk_i(clk), .uv_async_i(uv), .rst_o(rst_lo));
  por_stretch #(.CLK_KHZ(1000), .FILT_NS(4000), .HOLD_US(40), .ACTIVE_HIGH(1'b1)) dut_hi (
    .clk_i(clk), .uv_async_i(uv), .rst_o(rst_hi));

  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      total += 2;
      if (e.cyc != cyc) begin
        bad += 2;
        $display("FAIL %s missed sample cyc actual=%0d expected=%0d", e.tag, cyc, e.cyc);
      end else begin
        if (rst_lo !== !e.asrt) begin
          bad++;
          $display("FAIL %s R7 low-active cyc=%0d actual=%b expected=%b", e.tag, cyc, rst_lo, !e.asrt);
        end
        if (rst_hi !== e.asrt) begin
          bad++;
          $display("FAIL %s R7 high-active cyc=%0d actual=%b expected=%b", e.tag, cyc, rst_hi, e.asrt);
        end
      end
    end
  end

  task automatic expect_at(input int unsigned c, input bit a, input string t);
    exp_t e;
    e.cyc = c; e.asrt = a; e.tag = t;
    sbq.push_back(e);
  endtask

  task automatic go_cyc(input int unsigned n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic settle;
    while (sbq.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse(input int unsigned w, output int unsigned c);
    c = cyc;
    uv = 1'b1;
    go_cyc(c + w);
    uv = 1'b0;
  endtask

  initial begin
    int unsigned c;
    int unsigned c1;
    int unsigned c2;
    // R6 power-up with supply good from the start
    expect_at(0, 1'b1, "R6");
    expect_at(HOLD + 1, 1'b1, "R6");
    expect_at(HOLD + 2, 1'b0, "R6");
    settle();

    // R3 pulse of exactly the filter length
    c = cyc;
    expect_at(c + FILT + 3, 1'b0, "R3");
    expect_at(c + 12, 1'b0, "R3");
    pulse(FILT, c);
    settle();

    // R3 single-cycle pulse
    c = cyc;
    expect_at(c + 3, 1'b0, "R3");
    expect_at(c + 8, 1'b0, "R3");
    pulse(1, c);
    settle();

    // R4 pulse one cycle longer than the filter, then R2 release
    c = cyc;
    expect_at(c + FILT + 2, 1'b0, "R4");
    expect_at(c + FILT + 3, 1'b1, "R4");
    expect_at(c + FILT + 1 + HOLD + 1, 1'b1, "R2");
    expect_at(c + FILT + 1 + HOLD + 2, 1'b0, "R2");
    pulse(FILT + 1, c);
    settle();

    // R1 long dip, reset held throughout, R2 release after it
    c = cyc;
    expect_at(c + 15, 1'b1, "R1");
    expect_at(c + 29, 1'b1, "R1");
    expect_at(c + 30 + HOLD + 1, 1'b1, "R2");
    expect_at(c + 30 + HOLD + 2, 1'b0, "R2");
    pulse(30, c);
    settle();

    // R5 single-cycle dip in the middle of the hold restarts it
    c = cyc;
    expect_at(c + FILT + 3, 1'b1, "R5");
    pulse(10, c);
    c1 = c + 10;
    expect_at(c1 + HOLD + 2, 1'b1, "R5");
    go_cyc(c1 + 20);
    c2 = cyc;
    expect_at(c2 + 1 + HOLD + 1, 1'b1, "R5");
    expect_at(c2 + 1 + HOLD + 2, 1'b0, "R5");
    uv = 1'b1;
    go_cyc(c2 + 1);
    uv = 1'b0;
    settle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired at cyc=%0d actual=running expected=finished", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule